// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is the read path of a small on-chip cache. A processor presents a 24-bit byte address with a valid/ready handshake. The cache returns the addressed byte, together with one flag that says how the access was served. The primary store is direct-mapped: each 4-byte block has exactly one line it can occupy, chosen by the middle bits of the address. Beside it sits a small fully associative victim buffer that keeps lines recently pushed out of the primary store.

A primary hit answers on the cycle after acceptance, and the victim buffer plays no part in it. On a primary miss the victim buffer is searched on the next cycle. If the buffer holds the block, the block and the current occupant of its primary line trade places, and nothing is fetched. If both stores miss, the block is requested from memory. When it returns it fills the primary line, and the line it displaces is pushed into the victim buffer. Two blocks that map to the same primary line can then alternate cheaply instead of each access going to memory.

Top module: `dmc_victim`

## Requirements
- R1: The address splits, from the top, into a tag of `22-IDX_W` bits, a line index of `IDX_W` bits (`req_addr[IDX_W+1:2]`) and a byte offset `req_addr[1:0]`. The block number is `req_addr[23:2]`. With `IDX_W` = 14 the tag is 8 bits. The returned byte is bits `8*b+7 : 8*b` of the 32-bit block word, where b is the byte offset.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On a primary hit, `rsp_valid` and `rsp_pri_hit` are high for the single cycle after the accepting edge, and `rsp_byte` carries the addressed byte.
- R3: On a primary miss whose block is held in the victim buffer, `rsp_valid` and `rsp_vic_hit` are high in the second cycle after acceptance, and no memory request is made.
- R4: On a miss in both stores, `mem_req_valid` is high from the second cycle after acceptance, with `mem_req_blk` equal to the block number. It stays high and stable until an edge where `mem_rsp_valid` is high. In the cycle after that edge, `rsp_valid` and `rsp_miss` are high and the byte comes from `mem_rsp_data`.
- R5: Exchange: on a victim hit, the block moves into its primary line, and the line it displaces (if valid) takes over that victim entry. On a refill, a displaced valid primary line is inserted into the victim buffer. A block therefore lives in at most one of the two stores.
- R6: Victim insertion uses the lowest-numbered invalid entry when one exists. When the buffer is full it overwrites the entry under a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such overwrite.
- R7: Synchronous reset (`rst` high) invalidates every line of both stores. After reset `req_ready` is high and `rsp_valid` and `mem_req_valid` are low, so the first access to any address is a full miss.
- R8: While a victim lookup or a refill is pending, `req_ready` is low and `req_valid` is ignored: no extra response appears and the pending response belongs to the original address.
- R9: When `rsp_valid` is high, exactly one of `rsp_pri_hit`, `rsp_vic_hit` and `rsp_miss` is high. When `rsp_valid` is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Processor request valid |
| req_addr | input | 24 | Byte address of the request |
| req_ready | output | 1 | Cache idle and able to accept a request |
| rsp_valid | output | 1 | Response byte valid (one cycle) |
| rsp_byte | output | 8 | Addressed byte |
| rsp_pri_hit | output | 1 | Response served by the primary store |
| rsp_vic_hit | output | 1 | Response served by the victim buffer |
| rsp_miss | output | 1 | Response served by a memory refill |
| mem_req_valid | output | 1 | Refill request pending |
| mem_req_blk | output | 22 | Block number to fetch |
| mem_rsp_valid | input | 1 | Refill data valid |
| mem_rsp_data | input | 32 | Refill block, byte 0 in bits 7:0 |

## Verification
A primary hit is due on the first falling edge after the accepting rising edge. A victim hit is due one falling edge later. On a full miss the memory request is visible at that same second falling edge, and the response comes one falling edge after the edge that carries refill data. The bench drives each request at a falling edge and samples at exactly those falling edges. It also checks that nothing responds at the earlier sample points and that the request stays held across a random refill delay of zero to three cycles. A bench reference model of both stores predicts which of the three paths each access must take. Conflict-heavy address sequences make all three paths and the victim overwrite order occur often.

// File: rtl/dmc_victim.sv
module dmc_victim #(
  parameter int IDX_W    = 6,
  parameter int VB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [23:0] req_addr,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte,
  output logic        rsp_pri_hit,
  output logic        rsp_vic_hit,
  output logic        rsp_miss,
  output logic        mem_req_valid,
  output logic [21:0] mem_req_blk,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = 22 - IDX_W;
  localparam int VB_W  = $clog2(VB_DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_VCHK, S_FETCH} state_t;
  state_t state;

  logic [23:0]      a_q;
  logic [LINES-1:0] p_v;
  logic [TAG_W-1:0] p_tag [LINES];
  logic [31:0]      p_dat [LINES];

  logic [VB_DEPTH-1:0] vb_v;
  logic [21:0]         vb_blk [VB_DEPTH];
  logic [31:0]         vb_dat [VB_DEPTH];
  logic [VB_W-1:0]     vb_ptr;

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] b);
    return w[{b, 3'b000} +: 8];
  endfunction

  wire [IDX_W-1:0] in_idx = req_addr[IDX_W+1:2];
  wire [TAG_W-1:0] in_tag = req_addr[23:IDX_W+2];
  wire             pri_hit_in = p_v[in_idx] && (p_tag[in_idx] == in_tag);

  wire [21:0]      q_blk = a_q[23:2];
  wire [IDX_W-1:0] q_idx = a_q[IDX_W+1:2];
  wire [TAG_W-1:0] q_tag = a_q[23:IDX_W+2];

  wire        old_v   = p_v[q_idx];
  wire [21:0] old_blk = {p_tag[q_idx], q_idx};
  wire [31:0] old_dat = p_dat[q_idx];

  logic [VB_DEPTH-1:0] vb_match;
  for (genvar k = 0; k < VB_DEPTH; k++) begin : g_cmp
    assign vb_match[k] = vb_v[k] && (vb_blk[k] == q_blk);
  end

  wire vb_hit  = |vb_match;
  wire vb_full = &vb_v;

  logic [VB_W-1:0] vb_sel, ins_slot;
  always_comb begin
    vb_sel   = '0;
    ins_slot = vb_ptr;
    for (int k = VB_DEPTH - 1; k >= 0; k--) begin
      if (vb_match[k]) vb_sel = VB_W'(k);
      if (!vb_v[k])    ins_slot = VB_W'(k);
    end
  end

  wire [VB_W-1:0] ptr_nxt = (vb_ptr == VB_W'(VB_DEPTH - 1)) ? '0 : vb_ptr + 1'b1;

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_blk   = q_blk;

  always_ff @(posedge clk) begin
    rsp_valid   <= 1'b0;
    rsp_pri_hit <= 1'b0;
    rsp_vic_hit <= 1'b0;
    rsp_miss    <= 1'b0;
    if (rst) begin
      state  <= S_IDLE;
      p_v    <= '0;
      vb_v   <= '0;
      vb_ptr <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr;
          if (pri_hit_in) begin
            rsp_valid   <= 1'b1;
            rsp_pri_hit <= 1'b1;
            rsp_byte    <= pick(p_dat[in_idx], req_addr[1:0]);
          end else begin
            state <= S_VCHK;
          end
        end
        S_VCHK: if (vb_hit) begin
          p_v[q_idx]     <= 1'b1;
          p_tag[q_idx]   <= q_tag;
          p_dat[q_idx]   <= vb_dat[vb_sel];
          vb_v[vb_sel]   <= old_v;
          vb_blk[vb_sel] <= old_blk;
          vb_dat[vb_sel] <= old_dat;
          rsp_valid      <= 1'b1;
          rsp_vic_hit    <= 1'b1;
          rsp_byte       <= pick(vb_dat[vb_sel], a_q[1:0]);
          state          <= S_IDLE;
        end else begin
          state <= S_FETCH;
        end
        S_FETCH: if (mem_rsp_valid) begin
          p_v[q_idx]   <= 1'b1;
          p_tag[q_idx] <= q_tag;
          p_dat[q_idx] <= mem_rsp_data;
          if (old_v) begin
            vb_v[ins_slot]   <= 1'b1;
            vb_blk[ins_slot] <= old_blk;
            vb_dat[ins_slot] <= old_dat;
            if (vb_full) vb_ptr <= ptr_nxt;
          end
          rsp_valid <= 1'b1;
          rsp_miss  <= 1'b1;
          rsp_byte  <= pick(mem_rsp_data, a_q[1:0]);
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmc_victim_chk.sv
module dmc_victim_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_pri_hit,
  input logic        rsp_vic_hit,
  input logic        rsp_miss,
  input logic        mem_req_valid,
  input logic [21:0] mem_req_blk,
  input logic        mem_rsp_valid
);
  assert_one_flag_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $onehot({rsp_pri_hit, rsp_vic_hit, rsp_miss}));

  assert_quiet_flags_R9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> ({rsp_pri_hit, rsp_vic_hit, rsp_miss} == 3'b000));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_blk)));

  assert_refill_rsp_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_rsp_valid) |=> (rsp_valid && rsp_miss && !mem_req_valid));

  assert_accept_no_mem_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !mem_req_valid);

  assert_vic_no_mem_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_vic_hit |-> !mem_req_valid);
endmodule

bind dmc_victim dmc_victim_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_pri_hit(rsp_pri_hit), .rsp_vic_hit(rsp_vic_hit),
  .rsp_miss(rsp_miss), .mem_req_valid(mem_req_valid), .mem_req_blk(mem_req_blk),
  .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/dmc_victim_tb_top.sv
module dmc_victim_tb_top;
  localparam int IDX_W = 4;
  localparam int VB_D  = 4;
  localparam int LINES = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_pri_hit, rsp_vic_hit, rsp_miss, mem_req_valid;
  logic [7:0] rsp_byte;
  logic [21:0] mem_req_blk;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  dmc_victim #(.IDX_W(IDX_W), .VB_DEPTH(VB_D)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .rsp_pri_hit(rsp_pri_hit), .rsp_vic_hit(rsp_vic_hit), .rsp_miss(rsp_miss),
    .mem_req_valid(mem_req_valid), .mem_req_blk(mem_req_blk),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int n_run = 0, n_fail = 0;

  logic        m_pv  [LINES];
  logic [21:0] m_pblk[LINES];
  logic        m_vv  [VB_D];
  logic [21:0] m_vblk[VB_D];
  int          m_ptr;

  function automatic logic [31:0] memfn(input logic [21:0] b);
    return {b[7:0] ^ 8'hA5, b[15:8] ^ 8'h3C, {2'b00, b[21:16]} ^ 8'h71, b[7:0] + b[15:8]};
  endfunction

  function automatic logic [7:0] bsel(input logic [31:0] w, input logic [1:0] b);
    return w[8*b +: 8];
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < LINES; i++) m_pv[i] = 1'b0;
    for (int i = 0; i < VB_D; i++) m_vv[i] = 1'b0;
    m_ptr = 0;
  endtask

  // cls: 0 primary hit, 1 victim hit, 2 full miss
  task automatic model_access(input logic [23:0] a, output int cls);
    logic [21:0] blk = a[23:2];
    int idx = int'(a[IDX_W+1:2]);
    int hit = -1, slot;
    if (m_pv[idx] && m_pblk[idx] == blk) begin
      cls = 0;
      return;
    end
    for (int k = 0; k < VB_D; k++) if (m_vv[k] && m_vblk[k] == blk) hit = k;
    if (hit >= 0) begin
      cls = 1;
      m_vv[hit] = m_pv[idx];
      m_vblk[hit] = m_pblk[idx];
    end else begin
      cls = 2;
      if (m_pv[idx]) begin
        slot = -1;
        for (int k = VB_D - 1; k >= 0; k--) if (!m_vv[k]) slot = k;
        if (slot < 0) begin
          slot = m_ptr;
          m_ptr = (m_ptr + 1) % VB_D;
        end
        m_vv[slot] = 1'b1;
        m_vblk[slot] = m_pblk[idx];
      end
    end
    m_pv[idx] = 1'b1;
    m_pblk[idx] = blk;
  endtask

  task automatic do_req(input logic [23:0] a, input int want, input string rq, input bit poke);
    int cls, d;
    logic [7:0] eb = bsel(memfn(a[23:2]), a[1:0]);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    model_access(a, cls);
    if (want >= 0) chk(cls == want, {rq, " model path"}, cls, want);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (cls == 0) begin
      chk(rsp_valid && rsp_pri_hit && !rsp_vic_hit && !rsp_miss, "R2 primary hit flags",
          {rsp_valid, rsp_pri_hit, rsp_vic_hit, rsp_miss}, 4'b1100);
      chk(rsp_byte == eb, "R1 R2 primary byte", rsp_byte, eb);
      return;
    end
    chk(!rsp_valid && !req_ready, "R8 busy after primary miss", {rsp_valid, req_ready}, 2'b00);
    if (poke) begin
      req_valid = 1'b1;
      req_addr = a ^ 24'h000104;
    end
    @(negedge clk);
    if (cls == 1) begin
      chk(rsp_valid && rsp_vic_hit && !rsp_pri_hit && !rsp_miss && !mem_req_valid,
          {"R3 victim hit ", rq}, {rsp_valid, rsp_pri_hit, rsp_vic_hit, rsp_miss, mem_req_valid}, 5'b10100);
      chk(rsp_byte == eb, "R3 victim byte", rsp_byte, eb);
      req_valid = 1'b0;
      return;
    end
    chk(mem_req_valid && !rsp_valid, {"R4 refill request ", rq}, {mem_req_valid, rsp_valid}, 2'b10);
    chk(mem_req_blk == a[23:2], "R4 R1 refill block", mem_req_blk, a[23:2]);
    d = $urandom % 4;
    repeat (d) begin
      @(negedge clk);
      chk(mem_req_valid && !rsp_valid && !req_ready && mem_req_blk == a[23:2],
          "R4 R8 held during wait", {mem_req_valid, rsp_valid, req_ready}, 3'b100);
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data = memfn(a[23:2]);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    req_valid = 1'b0;
    chk(rsp_valid && rsp_miss && !rsp_pri_hit && !rsp_vic_hit && !mem_req_valid,
        "R4 R9 refill response", {rsp_valid, rsp_pri_hit, rsp_vic_hit, rsp_miss, mem_req_valid}, 5'b10010);
    chk(rsp_byte == eb, "R4 refill byte", rsp_byte, eb);
  endtask

  function automatic logic [23:0] mk(input int tag, input int idx, input int b);
    logic [21:0] blk = {18'(tag * 18'h1357 + 1), 4'(idx)};
    return {blk, 2'(b)};
  endfunction

  task automatic reset_dut();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    reset_dut();
    chk(req_ready && !rsp_valid && !mem_req_valid && !rsp_pri_hit && !rsp_vic_hit && !rsp_miss,
        "R7 reset state", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    do_req(mk(1, 3, 0), 2, "R7 first access misses", 1'b0);
    for (int b = 0; b < 4; b++) do_req(mk(1, 3, b), 0, "R1 byte select", 1'b0);

    do_req(mk(2, 3, 1), 2, "conflict", 1'b1);
    do_req(mk(1, 3, 2), 1, "R5 swap back", 1'b1);
    do_req(mk(2, 3, 3), 1, "R5 swap again", 1'b0);
    do_req(mk(2, 3, 0), 0, "R5 now primary", 1'b0);

    reset_dut();
    for (int t = 0; t < 6; t++) do_req(mk(10 + t, 0, t % 4), 2, "R6 fill order", 1'b0);
    do_req(mk(10, 0, 1), 2, "R6 oldest overwritten", 1'b0);
    do_req(mk(12, 0, 2), 1, "R6 later entry kept", 1'b0);
    do_req(mk(11, 0, 3), 2, "R6 pointer advanced", 1'b0);

    for (int n = 0; n < 600; n++)
      do_req(mk($urandom % 6, $urandom % 3, $urandom % 4), -1, "random", 1'($urandom % 2));

    reset_dut();
    do_req(mk(2, 3, 0), 2, "R7 reset invalidates", 1'b0);
    do_req(mk(2, 3, 0), 0, "R7 refilled", 1'b0);

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule